// File: doc/BRIEF.md
# Striped Generalized Rotate Unit

This unit performs a generalized rotate and bit permutation on a 32-bit word. Each request carries a 32-bit source, a 5-bit primary amount, a 5-bit alternate amount and a stripe flag. The source is written into both halves of a 64-bit working value. That value then passes through five conditional-move stages, with strides of 16, 8, 4, 2 and 1.

In every stage, each covered bit position picks one of the two amounts from its own index bits. It then tests one bit of that amount. If the bit is set, the position copies the bit one stride above it; otherwise it keeps its current value. The low 32 bits of the last stage are sign-extended to 64 bits to form the result. When both amounts are equal and stripe is clear, the operation is a plain rotate right. Other settings give a permutation of the source bits.

Requests enter and results leave through valid/ready handshakes. A parameter decides, for each stage, whether a register follows it. All stages share one advance signal, which is high whenever the output slot is empty or is being read in the same cycle.

Top module: `rotx_unit`

## Requirements
- R1: When both amounts equal s and stripe is 0, the low 32 bits of the result equal the source rotated right by s.
- R2: Result bits 63..32 are all copies of result bit 31.
- R3: When both amounts are 0 and stripe is 0, the low 32 bits of the result equal the source.
- R4: The working value starts as {source, source}. The stages use strides 16, 8, 4, 2 and 1 and cover positions 0 to 30+stride. For strides 16, 8, 4 and 2, a position uses the primary amount when its index bit 3, 2, 1 or 0 (respectively) is set, and the alternate amount otherwise. The stride-1 stage always uses the primary amount. The amount bit tested is bit 4, 3, 2, 1 and 0 for strides 16 to 1. When the tested bit is set, the position takes the bit stride places above it. Otherwise, and for positions the stage does not cover, the position keeps its value.
- R5: When stripe is 1, the stride-16 stage inverts the chosen amount before testing it, for positions whose index bit 2 is clear. No other stage is affected by stripe.
- R6: With the default of one register after every stage and no stall, a request accepted at a rising edge shows its result on out_valid and out_data after the fifth rising edge, counting the accepting edge. out_valid is low in every other cycle.
- R7: in_ready is high exactly when out_valid is low or out_ready is high.
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold their values into the next cycle.
- R9: While reset is asserted and directly after it, out_valid is low and in_ready is high.
- R10: Each accepted request yields exactly one result. Results leave in the order their requests were accepted, and none is lost or duplicated under output stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when in_valid is also high |
| in_src | input | 32 | Source word |
| in_amt | input | 5 | Primary amount |
| in_alt | input | 5 | Alternate amount |
| in_stripe | input | 1 | Stripe mode for the stride-16 stage |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Sign-extended result |

## Verification
With the default configuration, a result is due on the outputs after the fifth advancing edge, counting the edge that accepted its request. A stalled edge, where out_valid is high and out_ready is low, moves nothing. The bench keeps a queue of expected results, each with a count of the advancing edges it has seen. It samples the outputs one time unit after each falling edge and predicts out_valid, in_ready and out_data for that cycle from the queue. It compares them every clock, so an early, late, dropped or repeated result is caught in the cycle where it goes wrong. A separate phase drives out_ready in a pseudo-random pattern and checks that a held result does not change.

// File: rtl/rotx_pkg.sv
package rotx_pkg;
   localparam int WORD_W = 32;
   localparam int AMT_W  = 5;
   localparam int WIDE_W = 2 * WORD_W;
   localparam int NSTAGE = 5;

   typedef struct packed {
      logic              valid;
      logic [WIDE_W-1:0] bits;
      logic [AMT_W-1:0]  amt;
      logic [AMT_W-1:0]  alt;
      logic              stripe;
   } rotx_tok_t;

   function automatic int reg_count(logic [NSTAGE-1:0] m);
      int n = 0;
      for (int k = 0; k < NSTAGE; k++) n += int'(m[k]);
      return n;
   endfunction
endpackage

// File: rtl/rotx_stage.sv
module rotx_stage
   import rotx_pkg::*;
#(
   parameter int STAGE = 0
) (
   input  rotx_tok_t t_in,
   output rotx_tok_t t_out
);
   localparam int  STRIDE   = 16 >> STAGE;
   localparam int  LAST     = 30 + STRIDE;
   localparam int  TEST_BIT = (AMT_W - 1) - STAGE;
   localparam bit  PRI_ONLY = (STAGE == NSTAGE - 1);
   localparam int  SEL_BIT  = PRI_ONLY ? 0 : 3 - STAGE;

   if (STAGE < 0 || STAGE >= NSTAGE) begin : g_bad_stage
      $error("rotx_stage: STAGE out of range");
   end

   logic [AMT_W-1:0] pick;

   always_comb begin
      t_out = t_in;
      pick  = '0;
      for (int i = 0; i <= LAST; i++) begin
         pick = (PRI_ONLY || (((i >> SEL_BIT) & 1) != 0)) ? t_in.amt : t_in.alt;
         if (STAGE == 0 && t_in.stripe && (((i >> 2) & 1) == 0))
            pick = ~pick;
         if (pick[TEST_BIT])
            t_out.bits[i] = t_in.bits[i + STRIDE];
      end
   end
endmodule

// File: rtl/rotx_slot.sv
module rotx_slot
   import rotx_pkg::*;
#(
   parameter bit REG = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv,
   input  rotx_tok_t d,
   output rotx_tok_t q
);
   if (REG) begin : g_reg
      rotx_tok_t r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   r <= '0;
         else if (adv) r <= d;
      end
      assign q = r;
   end else begin : g_pass
      logic unused_pins;
      assign unused_pins = &{1'b0, clk, rst_n, adv};
      assign q = d;
   end
endmodule

// File: rtl/rotx_unit.sv
module rotx_unit
   import rotx_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                SHAMT_W    = 5,
   parameter logic [NSTAGE-1:0] STAGE_REGS = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [DATA_W-1:0]   in_src,
   input  logic [SHAMT_W-1:0]  in_amt,
   input  logic [SHAMT_W-1:0]  in_alt,
   input  logic                in_stripe,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [2*DATA_W-1:0] out_data
);
   localparam int LAT   = reg_count(STAGE_REGS);
   localparam int OCC_W = $clog2(NSTAGE + 2);

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("rotx_unit: DATA_W must equal the package word width");
   end
   if (SHAMT_W != AMT_W) begin : g_bad_amt
      $error("rotx_unit: SHAMT_W must equal the package amount width");
   end

   rotx_tok_t tok [0:NSTAGE];
   rotx_tok_t mid [0:NSTAGE-1];
   logic      adv;

   assign adv    = !tok[NSTAGE].valid || out_ready;
   assign tok[0] = '{valid: in_valid, bits: {in_src, in_src},
                     amt: in_amt, alt: in_alt, stripe: in_stripe};

   for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
      rotx_stage #(.STAGE(k)) i_stage (
         .t_in (tok[k]),
         .t_out(mid[k])
      );
      rotx_slot #(.REG(STAGE_REGS[k])) i_slot (
         .clk  (clk),
         .rst_n(rst_n),
         .adv  (adv),
         .d    (mid[k]),
         .q    (tok[k+1])
      );
   end

   assign in_ready  = adv;
   assign out_valid = tok[NSTAGE].valid;
   assign out_data  = {{DATA_W{tok[NSTAGE].bits[DATA_W-1]}}, tok[NSTAGE].bits[DATA_W-1:0]};

   logic unused_tail;
   assign unused_tail = ^{tok[NSTAGE].bits[2*DATA_W-1:DATA_W], tok[NSTAGE].amt,
                          tok[NSTAGE].alt, tok[NSTAGE].stripe};

   if (LAT > 0) begin : g_chk
      logic [OCC_W-1:0] occ;
      logic             in_fire, out_fire;
      assign in_fire  = in_valid && in_ready;
      assign out_fire = out_valid && out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    occ <= '0;
         else if (in_fire && !out_fire) occ <= occ + 1'b1;
         else if (!in_fire && out_fire) occ <= occ - 1'b1;
      end

      assert_ready_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid |-> in_ready);
      assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
      assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(rst_n) |-> (!out_valid && in_ready));
      assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
         occ <= OCC_W'(LAT));
      assert_empty_is_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (occ == '0) |-> !out_valid);
   end
endmodule

// File: tb/test_rotx_unit.sv
module test_rotx_unit;
   localparam int LAT = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_src = '0;
   logic [4:0]  in_amt = '0;
   logic [4:0]  in_alt = '0;
   logic        in_stripe = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] out_data;

   always #10 clk = ~clk;

   rotx_unit i_rotx_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_src(in_src), .in_amt(in_amt), .in_alt(in_alt), .in_stripe(in_stripe),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit stall_mode = 1'b0;
   bit last_in_fire = 1'b0;
   bit prev_hold = 1'b0;
   logic [63:0] prev_data = '0;
   logic [63:0] pend_data = '0;
   string       pend_req = "";

   logic [63:0] q_data[$];
   int          q_n[$];
   string       q_req[$];

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] sext(logic [31:0] w);
      return {{32{w[31]}}, w};
   endfunction

   // Behavioural model of the permutation, straight from R4 and R5
   function automatic logic [63:0] ref_perm(logic [31:0] s, logic [4:0] a, logic [4:0] b, bit st);
      logic [63:0] cur, nxt;
      cur = {s, s};
      for (int g = 0; g < 5; g++) begin
         int stride = 16 >> g;
         nxt = cur;
         for (int i = 0; i <= 30 + stride; i++) begin
            logic [4:0] use_amt;
            if (g == 4) use_amt = a;
            else use_amt = ((i >> (3 - g)) % 2 == 1) ? a : b;
            if (g == 0 && st && ((i / 4) % 2 == 0)) use_amt = ~use_amt;
            if (use_amt[4 - g]) nxt[i] = cur[i + stride];
         end
         cur = nxt;
      end
      return sext(cur[31:0]);
   endfunction

   function automatic logic [63:0] ref_rot(logic [31:0] s, logic [4:0] n);
      logic [63:0] d;
      d = {s, s} >> n;
      return sext(d[31:0]);
   endfunction

   task automatic step();
      bit exp_valid, adv, in_fire, out_fire;
      if (stall_mode) out_ready = ($urandom_range(0, 2) != 0);
      else            out_ready = 1'b1;
      #1;
      exp_valid = (q_data.size() > 0) && (q_n[0] == LAT);
      chk(out_valid === exp_valid, "R6 R10 out_valid", 64'(out_valid), 64'(exp_valid));
      chk(in_ready === (!exp_valid || out_ready), "R7 in_ready", 64'(in_ready), 64'(!exp_valid || out_ready));
      if (exp_valid) begin
         chk(out_data === q_data[0], q_req[0], out_data, q_data[0]);
         chk(out_data[63:32] === {32{out_data[31]}}, "R2 sign", out_data, sext(out_data[31:0]));
      end
      if (prev_hold)
         chk(out_valid && out_data === prev_data, "R8 hold", out_data, prev_data);
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      adv      = in_ready;
      in_fire  = in_valid && in_ready;
      out_fire = out_valid && out_ready;
      if (adv) begin
         if (out_fire && q_data.size() > 0) begin
            void'(q_data.pop_front()); void'(q_n.pop_front()); void'(q_req.pop_front());
         end
         foreach (q_n[j]) q_n[j]++;
      end
      if (in_fire) begin
         q_data.push_back(pend_data); q_n.push_back(1); q_req.push_back(pend_req);
      end
      last_in_fire = in_fire;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send(logic [31:0] s, logic [4:0] a, logic [4:0] b, bit st,
                       logic [63:0] exp, string req);
      in_valid = 1'b1; in_src = s; in_amt = a; in_alt = b; in_stripe = st;
      pend_data = exp; pend_req = req;
      do step(); while (!last_in_fire);
      in_valid = 1'b0;
   endtask

   task automatic drain(int n);
      in_valid = 1'b0;
      for (int k = 0; k < n; k++) step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog expired actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      #1;
      chk(out_valid === 1'b0, "R9 out_valid in reset", 64'(out_valid), 64'd0);
      chk(in_ready === 1'b1, "R9 in_ready in reset", 64'(in_ready), 64'd1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(out_valid === 1'b0, "R9 out_valid after reset", 64'(out_valid), 64'd0);
      @(negedge clk);

      // R3 identity
      send(32'h1234_5678, 5'd0, 5'd0, 1'b0, sext(32'h1234_5678), "R3 identity");
      send(32'h8000_0001, 5'd0, 5'd0, 1'b0, sext(32'h8000_0001), "R3 identity");
      drain(LAT + 2);

      // R6 single request, latency observed by per-cycle model
      send(32'hCAFE_F00D, 5'd4, 5'd4, 1'b0, ref_rot(32'hCAFE_F00D, 5'd4), "R6 R1 single");
      drain(LAT + 2);

      // R1 rotate for every amount, back to back
      for (int n = 0; n < 32; n++) begin
         logic [31:0] s = $urandom();
         send(s, 5'(n), 5'(n), 1'b0, ref_rot(s, 5'(n)), "R1 rotate");
      end
      drain(LAT + 2);

      // R4 differing amounts, stripe clear
      for (int k = 0; k < 40; k++) begin
         logic [31:0] s = $urandom();
         logic [4:0] a = 5'($urandom()), b = 5'($urandom());
         send(s, a, b, 1'b0, ref_perm(s, a, b, 1'b0), "R4 permute");
      end
      // R5 stripe set
      for (int k = 0; k < 40; k++) begin
         logic [31:0] s = $urandom();
         logic [4:0] a = 5'($urandom()), b = 5'($urandom());
         send(s, a, b, 1'b1, ref_perm(s, a, b, 1'b1), "R5 stripe");
      end
      send(32'h0000_FFFF, 5'd0, 5'd0, 1'b1, ref_perm(32'h0000_FFFF, 5'd0, 5'd0, 1'b1), "R5 stripe zero amounts");
      drain(LAT + 2);

      // R8 R10 output stalls
      stall_mode = 1'b1;
      for (int k = 0; k < 60; k++) begin
         logic [31:0] s = $urandom();
         logic [4:0] a = 5'($urandom()), b = 5'($urandom());
         bit st = 1'($urandom());
         send(s, a, b, st, ref_perm(s, a, b, st), "R10 R8 stalled order");
      end
      drain(4 * LAT);
      stall_mode = 1'b0;
      drain(2 * LAT);
      chk(q_data.size() == 0, "R10 all results delivered", 64'(q_data.size()), 64'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule